// File: doc/BRIEF.md
# Medium-rate infrared frame transmitter

This block turns a stream of bytes into one medium-rate infrared frame and drives the emitter pulse line. A frame opens with two flag octets. The payload bytes follow, then a 16-bit frame check sequence, then one closing flag. Payload and check sequence bits pass through HDLC-style zero insertion. The flags are sent as they are. Each line bit then becomes a pulse: a zero is a short pulse at the start of its bit cell, and a one leaves the line dark.

Two clock enables set the timing. `bit_en` marks the start of each bit cell. `sub_en` runs four times faster and marks quarter-cell boundaries. Bytes arrive on a valid/ready handshake with a last-byte marker. A frame starts as soon as `in_valid` is seen while the block is idle. The block then requests bytes one at a time until it takes a byte marked last. After that it appends the check sequence and the closing flag and returns to idle.

Top module: `mir_frame_tx`

## Requirements
- R1: During and right after synchronous reset, `ir_pulse` and `in_ready` are 0 and the block is idle.
- R2: A line bit of 0 drives `ir_pulse` high from the clock after its `bit_en` cycle. It stays high up to and including the cycle of the next `sub_en` that is not also a `bit_en`, so the pulse fills the first quarter of the cell.
- R3: A line bit of 1 keeps `ir_pulse` low for its whole bit cell.
- R4: Line bits go out in this order: two flags, the payload, the check sequence, one closing flag. Each flag is the octet 0,1,1,1,1,1,1,0 in line order.
- R5: Each payload byte goes out least significant bit first, and bytes go out in the order they were accepted.
- R6: The check sequence is CRC-16 with reflected polynomial 0x8408 and preset 0xFFFF. It covers payload bits only, not inserted zeros. It is sent complemented, least significant bit first.
- R7: Across the payload and check sequence together, a 0 is inserted after every run of five 1 bits. This includes a run that ends on the final check-sequence bit, in which case the zero comes just before the closing flag.
- R8: Flags get no inserted zeros and do not count toward a run. The run count is cleared at the start of every frame.
- R9: `in_ready` is 0 while the block is idle and while it sends flags or the check sequence. During the payload phase it is 1 exactly when the one-byte holding register is empty. Every byte offered up to the one marked last is accepted.
- R10: When idle, the line carries no pulses. A frame begins only on the clock after `in_valid` is seen high in idle, and its first line bit goes out on the next `bit_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-cell start enable, asserted together with every fourth `sub_en` |
| sub_en | input | 1 | Quarter-cell enable |
| in_data | input | BYTE_W | Payload byte |
| in_valid | input | 1 | Payload byte valid; also requests a new frame when idle |
| in_last | input | 1 | Marks the final payload byte of the frame |
| in_ready | output | 1 | Holding register can take a byte |
| ir_pulse | output | 1 | Registered emitter pulse line |

## Verification
The assertions assume `bit_en` only comes together with `sub_en`, on every fourth one. They also assume the byte source never leaves the holding register empty when a payload bit cell begins. The bench builds both enables from one counter that fixes this ratio and uses several quarter-cell lengths. It keeps `in_valid` high from the start of a frame until the last byte is taken, and it presents each next byte one clock after the previous one is accepted, well inside a bit cell. Each new frame is requested just after a `bit_en` edge, so the start never lands on a cell boundary.

// File: rtl/mir_pkg.sv
package mir_pkg;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_SOF,
    TX_DATA,
    TX_FCS,
    TX_EOF
  } tx_state_e;

  localparam int          DEF_BYTE_W    = 8;
  localparam int          DEF_FCS_W     = 16;
  localparam int          DEF_RUN       = 5;
  localparam int          DEF_FLAG_W    = 8;
  localparam int          DEF_N_SOF     = 2;
  localparam logic [15:0] DEF_CRC_POLY  = 16'h8408;
  localparam logic [15:0] DEF_CRC_INIT  = 16'hFFFF;
  localparam logic [7:0]  DEF_FLAG_PAT  = 8'h7E;

endpackage

// File: rtl/mir_crc16.sv
module mir_crc16 #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = 16'h8408,
  parameter logic [W-1:0] INIT = 16'hFFFF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init,
  input  logic         upd,
  input  logic         bit_in,
  output logic [W-1:0] crc_next
);

  logic [W-1:0] crc_q;

  // value of the register once bit_in has been folded in (reflected form)
  always_comb begin
    crc_next = {1'b0, crc_q[W-1:1]};
    if (crc_q[0] ^ bit_in) begin
      crc_next = crc_next ^ POLY;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || init) begin
      crc_q <= INIT;
    end else if (upd) begin
      crc_q <= crc_next;
    end
  end

endmodule

// File: rtl/mir_stuff_ctr.sv
module mir_stuff_ctr #(
  parameter  int RUN = 5,
  localparam int CW  = $clog2(RUN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic          bit_val,
  output logic [CW-1:0] ones_q,
  output logic          full
);

  assign full = (ones_q == CW'(RUN));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ones_q <= '0;
    end else if (step) begin
      if (full || !bit_val) begin
        ones_q <= '0;
      end else begin
        ones_q <= ones_q + CW'(1);
      end
    end
  end

endmodule

// File: rtl/mir_pulse_enc.sv
module mir_pulse_enc (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic sub_en,
  input  logic fire,
  input  logic bit_val,
  output logic pulse_q
);

  // pulse opens on the cell edge for a zero and closes on the next quarter edge
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
    end else if (bit_en) begin
      pulse_q <= fire && !bit_val;
    end else if (sub_en) begin
      pulse_q <= 1'b0;
    end
  end

endmodule

// File: rtl/mir_frame_tx.sv
module mir_frame_tx
  import mir_pkg::*;
#(
  parameter int                  BYTE_W   = DEF_BYTE_W,
  parameter int                  FCS_W    = DEF_FCS_W,
  parameter int                  STUFF_RUN = DEF_RUN,
  parameter int                  FLAG_W   = DEF_FLAG_W,
  parameter int                  N_SOF    = DEF_N_SOF,
  parameter logic [FCS_W-1:0]    CRC_POLY = DEF_CRC_POLY,
  parameter logic [FCS_W-1:0]    CRC_INIT = DEF_CRC_INIT,
  parameter logic [FLAG_W-1:0]   FLAG_PAT = DEF_FLAG_PAT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              sub_en,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic              ir_pulse
);

  localparam int SOF_BITS = N_SOF * FLAG_W;
  localparam int IDX_MAX  = (SOF_BITS > FCS_W) ? SOF_BITS : FCS_W;
  localparam int IDX_W    = $clog2(IDX_MAX + 1);
  localparam int FLAG_IW  = $clog2(FLAG_W);
  localparam int RUN_W    = $clog2(STUFF_RUN + 1);

  localparam logic [IDX_W-1:0] SOF_LAST  = IDX_W'(SOF_BITS - 1);
  localparam logic [IDX_W-1:0] EOF_LAST  = IDX_W'(FLAG_W - 1);
  localparam logic [IDX_W-1:0] BYTE_LAST = IDX_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0] FCS_LAST  = IDX_W'(FCS_W - 1);
  localparam logic [IDX_W-1:0] FCS_DONE  = IDX_W'(FCS_W);
  localparam logic [RUN_W-1:0] RUN_PRE   = RUN_W'(STUFF_RUN - 1);

  tx_state_e         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] sh_q;
  logic              have_q;
  logic              last_q;
  logic [FCS_W-1:0]  fcs_q;

  logic              busy;
  logic              stuff_phase;
  logic              emit;
  logic              ebit;
  logic              crc_upd;
  logic              cnt_step;
  logic              stuff_now;
  logic              will_fill;
  logic [RUN_W-1:0]  ones_cnt;
  logic [FCS_W-1:0]  crc_next;
  logic              flag_bit;
  logic              take;

  assign busy        = (state_q != TX_IDLE);
  assign stuff_phase = (state_q == TX_DATA) || (state_q == TX_FCS);
  assign in_ready    = (state_q == TX_DATA) && !have_q;
  assign take        = in_valid && in_ready;
  assign flag_bit    = FLAG_PAT[idx_q[FLAG_IW-1:0]];
  assign will_fill   = ebit && (ones_cnt == RUN_PRE);

  // ---------------------------------------------------------------
  // line bit selection for the current cell
  // ---------------------------------------------------------------
  always_comb begin
    emit     = 1'b0;
    ebit     = 1'b1;
    crc_upd  = 1'b0;
    cnt_step = 1'b0;
    unique case (state_q)
      TX_SOF, TX_EOF: begin
        emit = bit_en;
        ebit = flag_bit;
      end
      TX_DATA: begin
        if (stuff_now) begin
          emit     = bit_en;
          ebit     = 1'b0;
          cnt_step = bit_en;
        end else if (have_q) begin
          emit     = bit_en;
          ebit     = sh_q[0];
          crc_upd  = bit_en;
          cnt_step = bit_en;
        end
      end
      TX_FCS: begin
        if (stuff_now) begin
          emit     = bit_en;
          ebit     = 1'b0;
          cnt_step = bit_en;
        end else if (idx_q < FCS_DONE) begin
          emit     = bit_en;
          ebit     = fcs_q[0];
          cnt_step = bit_en;
        end
      end
      default: begin
        emit = 1'b0;
      end
    endcase
  end

  // ---------------------------------------------------------------
  // frame sequencer and byte holding register
  // ---------------------------------------------------------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TX_IDLE;
      idx_q   <= '0;
      sh_q    <= '0;
      have_q  <= 1'b0;
      last_q  <= 1'b0;
      fcs_q   <= '0;
    end else begin
      unique case (state_q)
        TX_IDLE: begin
          have_q <= 1'b0;
          idx_q  <= '0;
          if (in_valid) begin
            state_q <= TX_SOF;
          end
        end
        TX_SOF: begin
          if (bit_en) begin
            if (idx_q == SOF_LAST) begin
              state_q <= TX_DATA;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
        TX_DATA: begin
          if (take) begin
            sh_q   <= in_data;
            have_q <= 1'b1;
            last_q <= in_last;
          end
          if (bit_en && !stuff_now && have_q) begin
            sh_q <= {1'b0, sh_q[BYTE_W-1:1]};
            if (idx_q == BYTE_LAST) begin
              idx_q  <= '0;
              have_q <= 1'b0;
              if (last_q) begin
                state_q <= TX_FCS;
                fcs_q   <= ~crc_next;
              end
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
        TX_FCS: begin
          if (bit_en) begin
            if (stuff_now) begin
              if (idx_q == FCS_DONE) begin
                state_q <= TX_EOF;
                idx_q   <= '0;
              end
            end else if (idx_q < FCS_DONE) begin
              fcs_q <= {1'b0, fcs_q[FCS_W-1:1]};
              if (idx_q == FCS_LAST) begin
                if (will_fill) begin
                  idx_q <= FCS_DONE;
                end else begin
                  state_q <= TX_EOF;
                  idx_q   <= '0;
                end
              end else begin
                idx_q <= idx_q + IDX_W'(1);
              end
            end
          end
        end
        TX_EOF: begin
          if (bit_en) begin
            if (idx_q == EOF_LAST) begin
              state_q <= TX_IDLE;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
        default: begin
          state_q <= TX_IDLE;
        end
      endcase
    end
  end

  // ---------------------------------------------------------------
  // sub-blocks
  // ---------------------------------------------------------------
  mir_crc16 #(
    .W    (FCS_W),
    .POLY (CRC_POLY),
    .INIT (CRC_INIT)
  ) u_crc (
    .clk      (clk),
    .rst      (rst),
    .init     (!busy),
    .upd      (crc_upd),
    .bit_in   (ebit),
    .crc_next (crc_next)
  );

  mir_stuff_ctr #(
    .RUN (STUFF_RUN)
  ) u_stuff (
    .clk     (clk),
    .rst     (rst),
    .clr     (!busy),
    .step    (cnt_step),
    .bit_val (ebit),
    .ones_q  (ones_cnt),
    .full    (stuff_now)
  );

  mir_pulse_enc u_enc (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en),
    .sub_en  (sub_en),
    .fire    (emit),
    .bit_val (ebit),
    .pulse_q (ir_pulse)
  );

endmodule

// File: rtl/mir_frame_tx_chk.sv
module mir_frame_tx_chk #(
  parameter int RUN   = 5,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_en,
  input logic             sub_en,
  input logic             in_valid,
  input logic             in_ready,
  input logic             ir_pulse,
  input logic             busy,
  input logic             stuff_phase,
  input logic [CNT_W-1:0] ones_cnt
);

  AST_PULSE_OPENS_ON_CELL: assert property (@(posedge clk) disable iff (rst)
    $rose(ir_pulse) |-> $past(bit_en)); // R2

  AST_PULSE_QUARTER_END: assert property (@(posedge clk) disable iff (rst)
    (sub_en && !bit_en) |=> !ir_pulse); // R2

  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    ones_cnt <= CNT_W'(RUN)); // R7

  AST_STUFF_RESTARTS_RUN: assert property (@(posedge clk) disable iff (rst)
    (bit_en && stuff_phase && ones_cnt == CNT_W'(RUN)) |=> (ones_cnt == '0)); // R7

  AST_RUN_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (ones_cnt == '0)); // R8

  AST_READY_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> busy); // R9

  AST_FRAME_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(in_valid)); // R10

endmodule

bind mir_frame_tx mir_frame_tx_chk #(
  .RUN   (STUFF_RUN),
  .CNT_W (RUN_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bit_en      (bit_en),
  .sub_en      (sub_en),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .ir_pulse    (ir_pulse),
  .busy        (busy),
  .stuff_phase (stuff_phase),
  .ones_cnt    (ones_cnt)
);

// File: tb/tb_mir_frame_tx.sv
module tb_mir_frame_tx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       sub_en = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic       ir_pulse;

  always #5 clk = ~clk;

  mir_frame_tx dut (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .sub_en   (sub_en),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_ready (in_ready),
    .ir_pulse (ir_pulse)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // ---------------- enable generator ----------------
  int sub_div = 2;
  int sub_cnt = 0;
  int qtr = 0;

  always @(negedge clk) begin
    if (sub_cnt >= sub_div - 1) begin
      sub_cnt = 0;
      sub_en <= 1'b1;
      bit_en <= (qtr == 3);
      qtr = (qtr + 1) % 4;
    end else begin
      sub_cnt = sub_cnt + 1;
      sub_en <= 1'b0;
      bit_en <= 1'b0;
    end
  end

  // ---------------- reference model ----------------
  // tags: 0 opening flag, 1 payload, 2 check sequence, 3 inserted zero, 4 closing flag
  bit   expq[$];
  int   tagq[$];
  bit   exp_pulse = 1'b0;
  bit   last_bit = 1'b1;
  int   last_tag = 4;
  int   popped = 0;
  int   ones_run = 0;
  logic [7:0] txq[$];

  always @(posedge clk) begin
    if (rst) begin
      exp_pulse = 1'b0;
    end else if (bit_en) begin
      if (expq.size() > 0) begin
        last_bit = expq.pop_front();
        last_tag = tagq.pop_front();
        popped   = popped + 1;
        exp_pulse = (last_bit == 1'b0);
      end else begin
        exp_pulse = 1'b0;
      end
    end else if (sub_en) begin
      exp_pulse = 1'b0;
    end
  end

  function automatic string tag_of(input bit b, input int t, input int n);
    string s;
    s = b ? "R3" : "R2";
    if (n == 0) return {s, " R10"};
    case (t)
      0, 4: return {s, " R4 R8"};
      1: return {s, " R5"};
      2: return {s, " R6"};
      default: return {s, " R7"};
    endcase
  endfunction

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst && !finished) begin
      n_cmp = n_cmp + 1;
      if (ir_pulse !== exp_pulse) begin
        n_bad = n_bad + 1;
        $display("FAIL %s pulse at cycle %0d: got %b expected %b",
                 tag_of(last_bit, last_tag, popped), cyc, ir_pulse, exp_pulse);
      end
      if (expq.size() == 0 || popped == 0 || last_tag == 2 || last_tag == 4 ||
          (last_tag == 0 && popped < 16)) begin
        n_cmp = n_cmp + 1;
        if (in_ready !== 1'b0) begin
          n_bad = n_bad + 1;
          $display("FAIL R9 ready outside payload phase at cycle %0d: got %b expected 0",
                   cyc, in_ready);
        end
      end
    end
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog expired: got hang expected frame completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic push_stuffed(input bit b, input int t);
    expq.push_back(b);
    tagq.push_back(t);
    if (b) ones_run = ones_run + 1;
    else   ones_run = 0;
    if (ones_run == 5) begin
      expq.push_back(1'b0);
      tagq.push_back(3);
      ones_run = 0;
    end
  endtask

  task automatic push_flag(input int t);
    expq.push_back(1'b0);
    tagq.push_back(t);
    for (int k = 0; k < 6; k++) begin
      expq.push_back(1'b1);
      tagq.push_back(t);
    end
    expq.push_back(1'b0);
    tagq.push_back(t);
  endtask

  task automatic build_frame();
    logic [15:0] crc;
    logic [15:0] fcs;
    bit b;
    bit fb;
    crc = 16'hFFFF;
    ones_run = 0;
    push_flag(0);
    push_flag(0);
    foreach (txq[i]) begin
      for (int j = 0; j < 8; j++) begin
        b  = txq[i][j];
        fb = crc[0] ^ b;
        crc = crc >> 1;
        if (fb) crc = crc ^ 16'h8408;
        push_stuffed(b, 1);
      end
    end
    fcs = ~crc;
    for (int j = 0; j < 16; j++) begin
      push_stuffed(fcs[j], 2);
    end
    push_flag(4);
  endtask

  task automatic send_frame(input int div);
    int sent;
    int n;
    sub_div = div;
    n = txq.size();
    @(posedge clk iff bit_en);
    #1;
    build_frame();
    popped   = 0;
    sent     = 0;
    in_data  = txq[0];
    in_last  = (n == 1);
    in_valid = 1'b1;
    while (sent < n) begin
      @(negedge clk);
      if (in_ready) begin
        @(posedge clk);
        #1;
        sent = sent + 1;
        if (sent < n) begin
          in_data = txq[sent];
          in_last = (sent == n - 1);
        end else begin
          in_valid = 1'b0;
          in_last  = 1'b0;
        end
      end
    end
    while (expq.size() > 0) @(negedge clk);
    repeat (8 * 4 * div) @(negedge clk);
    n_cmp = n_cmp + 1;
    if (sent != n) begin
      n_bad = n_bad + 1;
      $display("FAIL R9 bytes accepted: got %0d expected %0d", sent, n);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    n_cmp = n_cmp + 2;
    if (ir_pulse !== 1'b0) begin
      n_bad = n_bad + 1;
      $display("FAIL R1 pulse in reset: got %b expected 0", ir_pulse);
    end
    if (in_ready !== 1'b0) begin
      n_bad = n_bad + 1;
      $display("FAIL R1 ready in reset: got %b expected 0", in_ready);
    end
    rst = 1'b0;
    // R10: idle gap with no request keeps the line dark (compared each clock)
    repeat (100) @(negedge clk);

    txq = '{8'hA5};
    send_frame(2);
    txq = '{8'hFF, 8'hFF, 8'h7E};
    send_frame(1);
    txq = '{8'h00, 8'h3F, 8'hF8, 8'h1F};
    send_frame(3);
    txq = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A};
    send_frame(2);
    txq = '{8'hFC, 8'h0F};
    send_frame(1);
    txq = '{8'hFF};
    send_frame(2);

    repeat (50) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule